// File: doc/BRIEF.md
# Microwire EEPROM host controller

This block is the host-side engine for a three-wire serial EEPROM. A request names a command (read, write, write-enable or write-disable), a word address and, for writes, a data word. The controller builds the serial frame and drives chip-select, the serial clock and the host data line. It samples the device data line and returns one response per request. A read response carries the data word. A write response reports whether the device finished programming in time.

The serial clock is derived from the system clock by a parameterized divider. Every frame opens with chip-select high and a single start bit. The opcode comes next, and after it the address and, where the command needs one, the data field, all MSB first. On reads the device sends one dummy zero ahead of the data, and the controller discards it. After a write frame, chip-select drops to start programming. The controller then raises chip-select again and watches the device data line until it reads 1. No fixed delay is used for this. If the device stays busy beyond a parameterized limit, the poll ends and the response carries a timeout flag.

Top module: `uwire_host`

## Requirements
- R1: While `rst_ni` is low, `cs_o`, `sk_o`, `di_o` and `rsp_valid_o` are 0 and `req_ready_o` is 1.
- R2: Each frame begins with `cs_o` rising while `sk_o` is low, and `di_o` carries the start bit 1. The two opcode bits follow: `req_op_i`=0 (read) sends 10, `req_op_i`=1 (write) sends 01, and `req_op_i`=2 (enable) and 3 (disable) send 00.
- R3: While `cs_o` is high, every half period of `sk_o` lasts `DIV` system clocks, including the span from the `cs_o` rise to the first rising edge. `di_o` changes only on a falling `sk_o` edge. `sk_o` is low whenever `cs_o` is low.
- R4: A write frame is exactly 27 rising edges: start bit, opcode 01, the 8 address bits and then the 16 data bits, all MSB first.
- R5: A read frame is exactly 28 rising edges: start bit, opcode 10, the 8 address bits, then 17 edges with `di_o` at 0. The device line is sampled on each rising edge. The sample at edge 12 is the dummy bit and is discarded. Edges 13 to 28 give the data word MSB first, returned on `rsp_rdata_o`.
- R6: An enable frame is 11 rising edges carrying 1,00,11 followed by six 0 bits. A disable frame is 11 edges carrying 1,00,00 followed by six 0 bits.
- R7: After a write frame, `cs_o` goes low and later rises again with no `sk_o` activity. It stays high until `do_i` is sampled at 1, then falls before the response is offered.
- R8: If `do_i` stays 0 for `BUSY_MAX` consecutive poll samples, one per `DIV` clocks, the poll ends after exactly `BUSY_MAX`*`DIV` clocks of `cs_o` high and `rsp_timeout_o` is 1. Otherwise `rsp_timeout_o` is 0.
- R9: Between any two periods of `cs_o` high, `cs_o` stays low for at least 2*`DIV` system clocks (one serial period).
- R10: A request is taken only while `req_ready_o` is 1. `req_ready_o` stays 0 from acceptance until the response has been taken. `rsp_valid_o`, `rsp_rdata_o` and `rsp_timeout_o` hold steady while `rsp_ready_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle and able to take a request |
| req_op_i | input | 2 | Command: 0 read, 1 write, 2 enable, 3 disable |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken |
| rsp_rdata_o | output | DATA_W | Read data, 0 for other commands |
| rsp_timeout_o | output | 1 | Busy poll exceeded the limit |
| cs_o | output | 1 | Chip-select to the device |
| sk_o | output | 1 | Serial clock to the device |
| di_o | output | 1 | Serial data to the device |
| do_i | input | 1 | Serial data and status from the device |

## Verification
The bench builds the controller with `DIV`=2 and `BUSY_MAX`=64, keeping `ADDR_W`=8 and `DATA_W`=16. With the short divider, a full sequence of enable, disable, write, read-back and ignored writes fits in a few thousand cycles. With the small busy limit, a device model forced to report busy reaches the timeout path after 128 cycles of polling. A normal programming time of 80 cycles stays below that limit, so an ordinary poll must wait for real readiness rather than time out.

// File: rtl/uwire_pkg.sv
package uwire_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_WEN   = 2'd2,
    OP_WDS   = 2'd3
  } uw_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP,
    ST_POLL,
    ST_RESP
  } uw_state_e;
endpackage

// File: rtl/uwire_tick.sv
module uwire_tick #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!run_i || cnt_q == LAST) cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/uwire_shreg.sv
module uwire_shreg #(
  parameter int FRAME_W = 27,
  parameter int DATA_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               shift_i,
  input  logic               cap_i,
  input  logic               bit_i,
  output logic               msb_o,
  output logic [DATA_W-1:0]  word_o
);
  logic [FRAME_W-1:0] tx_q;
  logic [DATA_W-1:0]  rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tx_q <= '0;
    else if (load_i)  tx_q <= frame_i;
    else if (shift_i) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
  end

  // every sampled bit shifts in; the dummy falls off the top by the last edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rx_q <= '0;
    else if (load_i) rx_q <= '0;
    else if (cap_i)  rx_q <= {rx_q[DATA_W-2:0], bit_i};
  end

  assign msb_o  = tx_q[FRAME_W-1];
  assign word_o = rx_q;
endmodule

// File: rtl/uwire_poll.sv
module uwire_poll #(
  parameter int BUSY_MAX = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic expired_o
);
  localparam int PW = $clog2(BUSY_MAX + 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == PW'(BUSY_MAX - 1));
endmodule

// File: rtl/uwire_host.sv
module uwire_host
  import uwire_pkg::*;
#(
  parameter int DIV      = 4,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int BUSY_MAX = 20000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_timeout_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  input  logic              do_i
);
  localparam int FRAME_W = 3 + ADDR_W + DATA_W;
  localparam int LEN_RD  = 4 + ADDR_W + DATA_W;
  localparam int LEN_WR  = FRAME_W;
  localparam int LEN_EW  = 3 + ADDR_W;
  localparam int CNT_W   = $clog2(LEN_RD + 1);

  uw_state_e         state_q;
  uw_op_e            op_q;
  logic              cs_q, sk_q, polled_q, to_q, rsp_valid_q;
  logic [CNT_W-1:0]  cnt_q, len_q, len_d;
  logic [DATA_W-1:0] rdata_q, rx_word;
  logic [FRAME_W-1:0] frame_d;
  logic tick, run, tx_msb, accept, shift_tx, cap, poll_exp;

  always_comb begin
    frame_d = '0;
    len_d   = CNT_W'(LEN_EW);
    case (uw_op_e'(req_op_i))
      OP_READ: begin
        frame_d = {3'b110, req_addr_i, {DATA_W{1'b0}}};
        len_d   = CNT_W'(LEN_RD);
      end
      OP_WRITE: begin
        frame_d = {3'b101, req_addr_i, req_wdata_i};
        len_d   = CNT_W'(LEN_WR);
      end
      OP_WEN:  frame_d[FRAME_W-1 -: 5] = 5'b10011;
      default: frame_d[FRAME_W-1 -: 3] = 3'b100;
    endcase
  end

  assign accept   = (state_q == ST_IDLE) && req_valid_i;
  assign run      = (state_q == ST_SHIFT) || (state_q == ST_GAP) || (state_q == ST_POLL);
  assign cap      = (state_q == ST_SHIFT) && tick && !sk_q;
  assign shift_tx = (state_q == ST_SHIFT) && tick && sk_q && (cnt_q != len_q);

  uwire_tick #(.DIV(DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .tick_o(tick)
  );

  uwire_shreg #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_shreg (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept), .frame_i(frame_d),
    .shift_i(shift_tx), .cap_i(cap), .bit_i(do_i),
    .msb_o(tx_msb), .word_o(rx_word)
  );

  uwire_poll #(.BUSY_MAX(BUSY_MAX)) u_poll (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(state_q != ST_POLL),
    .inc_i(tick), .expired_o(poll_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      op_q        <= OP_READ;
      cs_q        <= 1'b0;
      sk_q        <= 1'b0;
      cnt_q       <= '0;
      len_q       <= '0;
      polled_q    <= 1'b0;
      to_q        <= 1'b0;
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          state_q  <= ST_SHIFT;
          op_q     <= uw_op_e'(req_op_i);
          len_q    <= len_d;
          cnt_q    <= '0;
          cs_q     <= 1'b1;
          sk_q     <= 1'b0;
          polled_q <= 1'b0;
          to_q     <= 1'b0;
        end
        ST_SHIFT: if (tick) begin
          if (!sk_q) begin
            sk_q  <= 1'b1;
            cnt_q <= cnt_q + 1'b1;
          end else begin
            sk_q <= 1'b0;
            if (cnt_q == len_q) begin
              cs_q    <= 1'b0;
              cnt_q   <= '0;
              state_q <= ST_GAP;
            end
          end
        end
        // two ticks low = one serial period
        ST_GAP: if (tick) begin
          if (cnt_q == CNT_W'(1)) begin
            cnt_q <= '0;
            if (op_q == OP_WRITE && !polled_q) begin
              cs_q    <= 1'b1;
              state_q <= ST_POLL;
            end else begin
              state_q     <= ST_RESP;
              rsp_valid_q <= 1'b1;
              rdata_q     <= (op_q == OP_READ) ? rx_word : '0;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_POLL: if (tick && (do_i || poll_exp)) begin
          cs_q     <= 1'b0;
          polled_q <= 1'b1;
          to_q     <= !do_i;
          state_q  <= ST_GAP;
        end
        ST_RESP: if (rsp_ready_i) begin
          rsp_valid_q <= 1'b0;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o   = (state_q == ST_IDLE);
  assign rsp_valid_o   = rsp_valid_q;
  assign rsp_rdata_o   = rdata_q;
  assign rsp_timeout_o = to_q;
  assign cs_o          = cs_q;
  assign sk_o          = sk_q;
  assign di_o          = cs_q && (state_q == ST_SHIFT) && tx_msb;
endmodule

// File: rtl/uwire_host_chk.sv
module uwire_host_chk #(
  parameter int DIV    = 4,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic              rsp_timeout_o,
  input logic              cs_o,
  input logic              sk_o,
  input logic              di_o
);
  localparam int GAP = 2 * DIV;
  localparam int GW  = $clog2(GAP + 1);

  logic [GW-1:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    low_cnt_q <= GW'(GAP);
    else if (cs_o)                  low_cnt_q <= '0;
    else if (low_cnt_q < GW'(GAP))  low_cnt_q <= low_cnt_q + 1'b1;
  end

  // R3
  sk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_o |-> !sk_o);

  // R3
  di_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o && $past(cs_o) && !$stable(di_o)) |-> $fell(sk_o));

  // R9
  cs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> (low_cnt_q >= GW'(GAP)));

  // R10
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_rdata_o) && $stable(rsp_timeout_o)));

  // R10
  req_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!rsp_valid_o && !cs_o));
endmodule

bind uwire_host uwire_host_chk #(.DIV(DIV), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i),
  .rsp_rdata_o(rsp_rdata_o), .rsp_timeout_o(rsp_timeout_o),
  .cs_o(cs_o), .sk_o(sk_o), .di_o(di_o)
);

// File: tb/tb_uwire_host.sv
module tb_uwire_host;
  import uwire_pkg::*;

  localparam int DIV      = 2;
  localparam int BUSY_MAX = 64;
  localparam int BUSY_CYC = 80;

  logic clk, rst_ni;
  logic req_valid_i, req_ready_o, rsp_valid_o, rsp_ready_i, rsp_timeout_o;
  logic [1:0] req_op_i;
  logic [7:0] req_addr_i;
  logic [15:0] req_wdata_i, rsp_rdata_o;
  logic cs_o, sk_o, di_o, do_i;

  uwire_host #(.DIV(DIV), .ADDR_W(8), .DATA_W(16), .BUSY_MAX(BUSY_MAX)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_op_i(req_op_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i), .rsp_rdata_o(rsp_rdata_o),
    .rsp_timeout_o(rsp_timeout_o), .cs_o(cs_o), .sk_o(sk_o), .di_o(di_o), .do_i(do_i)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  int          dv_cnt = 0;
  logic [31:0] dv_sh = '0;
  logic [16:0] rd_sh = '0;
  bit          rd_act = 0, wen = 0, pend = 0, stuck = 0;
  logic [7:0]  p_addr = '0;
  logic [15:0] p_data = '0;
  bit [15:0]   mem [256];
  bit          mem_v [256];
  int          busy_end = 0;

  function automatic logic [15:0] dflt(input logic [7:0] a);
    return {a, ~a};
  endfunction

  function automatic logic [15:0] mem_rd(input logic [7:0] a);
    return mem_v[a] ? mem[a] : dflt(a);
  endfunction

  always @(posedge sk_o or negedge cs_o) begin
    if (!cs_o) begin
      dv_cnt = 0;
      rd_act = 0;
      if (pend && wen) begin
        mem[p_addr]   = p_data;
        mem_v[p_addr] = 1;
        busy_end      = cyc + BUSY_CYC;
      end
      pend = 0;
    end else begin
      dv_cnt = dv_cnt + 1;
      dv_sh  = {dv_sh[30:0], di_o};
      if (rd_act) rd_sh = {rd_sh[15:0], 1'b0};
      if (dv_cnt == 11 && dv_sh[10:8] == 3'b110) begin
        rd_sh  = {1'b0, mem_rd(dv_sh[7:0])};
        rd_act = 1;
      end
      if (dv_cnt == 5 && dv_sh[4:2] == 3'b100) begin
        if (dv_sh[1:0] == 2'b11) wen = 1;
        else if (dv_sh[1:0] == 2'b00) wen = 0;
      end
      if (dv_cnt == 27 && dv_sh[26:24] == 3'b101) begin
        pend   = 1;
        p_addr = dv_sh[23:16];
        p_data = dv_sh[15:0];
      end
    end
  end

  assign do_i = cs_o && (rd_act ? rd_sh[16] : !(stuck || cyc < busy_end));

  // ---------------- scoreboard ----------------
  typedef struct { int len; logic [31:0] bits; int kind; bit to; } frm_t;
  typedef struct { logic [15:0] rd; bit to; } rsp_t;
  frm_t fq[$];
  rsp_t rq[$];

  function automatic string req_of(input int kind);
    case (kind)
      0: return "R2 R5";
      1: return "R2 R4";
      2: return "R2 R6";
      default: return "R7";
    endcase
  endfunction

  task automatic issue(input uw_op_e op, input logic [7:0] a, input logic [15:0] d,
                       input logic [15:0] exp_rd, input bit exp_to);
    frm_t f;
    rsp_t r;
    f.to = 0;
    case (op)
      OP_READ:  begin f.len = 28; f.bits = {3'b110, a} << 17;        f.kind = 0; end
      OP_WRITE: begin f.len = 27; f.bits = {5'b0, 3'b101, a, d};     f.kind = 1; end
      OP_WEN:   begin f.len = 11; f.bits = 32'b100_1100_0000;       f.kind = 2; end
      default:  begin f.len = 11; f.bits = 32'b100_0000_0000;       f.kind = 2; end
    endcase
    fq.push_back(f);
    if (op == OP_WRITE) begin
      f.len = 0; f.bits = '0; f.kind = 3; f.to = exp_to;
      fq.push_back(f);
    end
    r.rd = exp_rd;
    r.to = exp_to;
    rq.push_back(r);
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    req_valid_i = 1;
    req_op_i    = op;
    req_addr_i  = a;
    req_wdata_i = d;
    @(negedge clk);
    req_valid_i = 0;
    while (rq.size() != 0) @(negedge clk);
  endtask

  // response ready pattern, changed just after the active edge
  initial begin
    rsp_ready_i = 0;
    forever begin
      @(posedge clk);
      #1 rsp_ready_i = (cyc % 3) != 0;
    end
  end

  // monitor
  initial begin
    logic prev_cs = 0, prev_sk = 0, prev_di = 0, prev_hold = 0;
    logic [15:0] prev_rd = '0;
    int low_cnt = 2 * DIV, hi_cnt = 0, since_tog = 0, rises = 0;
    logic [31:0] bits = '0;
    frm_t f;
    rsp_t r;
    @(posedge rst_ni);
    forever begin
      @(negedge clk);
      if (cs_o && !prev_cs) begin
        chk(low_cnt >= 2 * DIV, "R9 cs low gap", low_cnt, 2 * DIV);
        rises = 0; bits = '0; since_tog = 0; hi_cnt = 0;
      end
      if (cs_o) hi_cnt++;
      if (cs_o && prev_cs) begin
        since_tog++;
        if (sk_o != prev_sk) begin
          chk(since_tog == DIV, "R3 half period", since_tog, DIV);
          since_tog = 0;
          if (sk_o) begin
            rises++;
            bits = {bits[30:0], di_o};
          end
        end
        if (di_o != prev_di) chk(prev_sk && !sk_o, "R3 di edge", {sk_o, prev_sk}, 2'b01);
      end
      if (!cs_o && prev_cs) begin
        chk(!sk_o, "R3 sk low at cs fall", sk_o, 0);
        if (fq.size() == 0) chk(0, "R7 unexpected cs period", rises, 0);
        else begin
          f = fq.pop_front();
          chk(rises == f.len, req_of(f.kind), rises, f.len);
          chk(bits == f.bits, req_of(f.kind), bits, f.bits);
          if (f.kind == 3 && f.to) chk(hi_cnt == BUSY_MAX * DIV, "R8 poll length", hi_cnt, BUSY_MAX * DIV);
          if (f.kind == 3 && !f.to) chk(cyc >= busy_end, "R7 poll ended while busy", cyc, busy_end);
        end
        low_cnt = 0;
      end
      if (!cs_o) low_cnt++;
      if (prev_hold) chk(rsp_valid_o && rsp_rdata_o == prev_rd, "R10 hold", rsp_rdata_o, prev_rd);
      if (rsp_valid_o && rsp_ready_i) begin
        if (rq.size() == 0) chk(0, "R10 unexpected response", rsp_rdata_o, 0);
        else begin
          r = rq.pop_front();
          chk(rsp_rdata_o == r.rd, "R5 read data", rsp_rdata_o, r.rd);
          chk(rsp_timeout_o == r.to, "R8 timeout flag", rsp_timeout_o, r.to);
          chk(fq.size() == 0, "R7 response before frames done", fq.size(), 0);
        end
      end
      if (cs_o || rsp_valid_o) chk(!req_ready_o, "R10 ready while busy", req_ready_o, 0);
      prev_hold = rsp_valid_o && !rsp_ready_i;
      prev_rd   = rsp_rdata_o;
      prev_cs = cs_o; prev_sk = sk_o; prev_di = di_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 0;
    req_valid_i = 0; req_op_i = '0; req_addr_i = '0; req_wdata_i = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!cs_o, "R1 cs", cs_o, 0);
    chk(!sk_o, "R1 sk", sk_o, 0);
    chk(!di_o, "R1 di", di_o, 0);
    chk(req_ready_o, "R1 ready", req_ready_o, 1);
    chk(!rsp_valid_o, "R1 rsp_valid", rsp_valid_o, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk);

    issue(OP_WDS,   8'h00, 16'h0000, 16'h0000, 0);
    issue(OP_WRITE, 8'h05, 16'h1234, 16'h0000, 0);   // R6 disabled write ignored
    issue(OP_READ,  8'h05, 16'h0000, dflt(8'h05), 0);
    issue(OP_WEN,   8'h00, 16'h0000, 16'h0000, 0);
    issue(OP_WRITE, 8'h12, 16'hBEEF, 16'h0000, 0);   // R7 real busy poll
    issue(OP_READ,  8'h12, 16'h0000, 16'hBEEF, 0);
    issue(OP_WRITE, 8'hFF, 16'h8001, 16'h0000, 0);
    issue(OP_READ,  8'hFF, 16'h0000, 16'h8001, 0);
    issue(OP_READ,  8'h00, 16'h0000, dflt(8'h00), 0);
    stuck = 1;
    issue(OP_WRITE, 8'h40, 16'h5555, 16'h0000, 1);   // R8 timeout
    stuck = 0;
    repeat (100) @(negedge clk);
    issue(OP_READ,  8'h40, 16'h0000, 16'h5555, 0);
    issue(OP_WDS,   8'h00, 16'h0000, 16'h0000, 0);
    issue(OP_WRITE, 8'h12, 16'h0000, 16'h0000, 0);
    issue(OP_READ,  8'h12, 16'h0000, 16'hBEEF, 0);   // R6 disable effective
    repeat (10) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule